// File: doc/BRIEF.md
# Sampled Entropy Collector

This block turns a raw, free-running entropy bit into words of random data that software reads over a 32-bit register bus. Software sets the interval between samples and an output length of 64, 128, 192 or 256 bits. It then turns the generator on and sets the start bit. Every N clock cycles the block latches one bit from the entropy input and places it in a 256-bit data buffer. When the requested number of bits is in the buffer, the start bit drops back to 0 by itself. Software polls the start bit until it reads 0 and then reads the data words.

The control register has a write mask in its upper half. A write changes only the control bits whose mask bits are set, so software can set start without touching the length or speed fields. Two control bits are driven out as a speed setting for the entropy source.

Top module: `sampled_trng`

## Requirements
- R1: A write to the control register (offset 0x400) changes control bit i only when bit i+16 of the written word is 1. Control bits 15:6 always read as 0.
- R2: Control bits [5:4] hold a length field L. A collection gathers 64*(L+1) bits. The start bit (control bit 0) reads 1 while the collection runs. It clears itself on the clock edge that captures the last bit, and the enable bit (bit 1) stays 1.
- R3: Control bits [3:2] are driven on `osc_speed` continuously.
- R4: Setting start while enable (bit 1) is 0 has no effect: start reads 0 and the data words do not change.
- R5: The period register (offset 0x404) resets to 1000 and reads back what was written. With period P, bit k of a collection is taken from `entropy_in` at the (P*(k+1))-th rising edge after the edge that set start. A period of 0 acts as 1.
- R6: Captured bit k appears in data word k/32, at bit position k%32. Data word w is read at offset 0x410+4*w, for w from 0 to 7.
- R7: Setting start (a 0-to-1 change with enable 1) clears all data words. After a collection ends, the words keep their value until the next start.
- R8: Writing 0 to the control register with mask 0xFFFF clears enable and start and stops a running collection. Bits already captured stay in the data words.
- R9: Reads of unmapped offsets return 0. Writes to the data words are ignored.
- R10: After reset, the control register reads 0, the period register reads 1000, all data words read 0 and `osc_speed` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not reading |
| entropy_in | input | 1 | Raw entropy bit |
| osc_speed | output | 2 | Speed setting for the entropy source |

## Verification
The bench runs a collection for every length at periods 0, 1, 2 and 3. It checks each word bit by bit against the entropy values it saw at the exact capture edges. This catches any off-by-one in the sample counter or the bit index, and any error in word packing. The lengths run from longest to shortest, so a design that failed to clear the buffer at start would leave stale upper words behind. The bench also checks that start is still set one cycle before the final capture, which exposes a collection that ends one bit early. Further checks cover a masked write that must leave the other fields alone, a start without enable that must be ignored, an abort that must keep the captured bits, and a write to a data word that must not alter it.

// File: rtl/sampled_trng.sv
module sampled_trng #(
  parameter int          AW         = 12,
  parameter logic [31:0] PERIOD_RST = 32'd1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          entropy_in,
  output logic [1:0]    osc_speed
);
  localparam int MAX_BITS = 256;
  localparam int IDX_W    = $clog2(MAX_BITS + 1);
  localparam logic [AW-1:0] CTL_A  = AW'(12'h400);
  localparam logic [AW-1:0] PER_A  = AW'(12'h404);
  localparam logic [AW-1:0] DATA_A = AW'(12'h410);

  logic [5:0]          ctl;
  logic [31:0]         period;
  logic [MAX_BITS-1:0] data;
  logic [IDX_W-1:0]    idx;
  logic [31:0]         cnt;
  logic [1:0]          len_q;

  wire start = ctl[0];
  wire en    = ctl[1];
  assign osc_speed = ctl[3:2];

  wire        ctl_we = bus_valid && bus_write && bus_addr == CTL_A;
  wire        per_we = bus_valid && bus_write && bus_addr == PER_A;
  wire [5:0]  ctl_m  = (ctl & ~bus_wdata[21:16]) | (bus_wdata[5:0] & bus_wdata[21:16]);
  wire        kick   = ctl_m[0] && ctl_m[1] && !start;
  wire [31:0] per_m1 = (period == 32'd0) ? 32'd0 : period - 32'd1;
  wire        hit    = cnt >= per_m1;
  wire [IDX_W-1:0] last_idx = IDX_W'({len_q, 6'h3F});
  wire        done   = start && hit && idx == last_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl    <= '0;
      period <= PERIOD_RST;
      data   <= '0;
      idx    <= '0;
      cnt    <= '0;
      len_q  <= '0;
    end else begin
      if (start) begin
        if (hit) begin
          cnt                    <= '0;
          data[idx[IDX_W-2:0]]   <= entropy_in;
          idx                    <= idx + 1'b1;
          if (idx == last_idx) ctl[0] <= 1'b0;
        end else begin
          cnt <= cnt + 32'd1;
        end
      end
      if (ctl_we) begin
        ctl[5:1] <= ctl_m[5:1];
        ctl[0]   <= ctl_m[1] && (kick || (ctl_m[0] && !done));
        if (kick) begin
          data  <= '0;
          idx   <= '0;
          cnt   <= '0;
          len_q <= ctl_m[5:4];
        end
      end
      if (per_we) period <= bus_wdata;
    end
  end

  wire [AW-1:0] doff = bus_addr - DATA_A;

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write) begin
      if (bus_addr == CTL_A)
        bus_rdata = {26'd0, ctl};
      else if (bus_addr == PER_A)
        bus_rdata = period;
      else if (doff < AW'(32) && doff[1:0] == 2'b00)
        bus_rdata = data[doff[4:2]*32 +: 32];
    end
  end

  assert_start_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> en);
  assert_idx_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> idx <= last_idx);
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !bus_valid) |=> $stable(data));
  assert_mask_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !bus_wdata[17]) |=> $stable(en));
  assert_speed_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && bus_wdata[19:18] == 2'b00) |=> $stable(osc_speed));
  assert_no_early_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !hit && !ctl_we) |=> $stable(idx));
endmodule

// File: tb/sampled_trng_tb_top.sv
module sampled_trng_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_valid = 0, bus_write = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        entropy_in;
  logic [1:0]  osc_speed;
  logic [15:0] lfsr = 16'hACE1;

  int total = 0, bad = 0;
  bit finished = 0;
  logic exp_bits [256];

  sampled_trng dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .entropy_in(entropy_in), .osc_speed(osc_speed));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  assign entropy_in = lfsr[0];

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] expv);
    total++;
    if (got !== expv) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, expv);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2, e;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);

    rd(12'h400, v); chk("R10 ctl reset", v, 0);
    rd(12'h404, v); chk("R10 period reset", v, 1000);
    for (int w = 0; w < 8; w++) begin
      rd(12'h410 + 12'(4*w), v); chk("R10 data reset", v, 0);
    end
    chk("R10 speed reset", {30'd0, osc_speed}, 0);

    wr(12'h400, 32'h003F_0008);
    rd(12'h400, v); chk("R1 full mask", v, 32'h08);
    chk("R3 speed out", {30'd0, osc_speed}, 2);
    wr(12'h400, 32'h0004_003F);
    rd(12'h400, v); chk("R1 single bit mask", v, 32'h0C);
    chk("R3 speed out 3", {30'd0, osc_speed}, 3);
    wr(12'h400, 32'hFFC0_FFC0);
    rd(12'h400, v); chk("R1 upper bits zero", v, 32'h0C);

    wr(12'h400, 32'h0001_0001);
    repeat (10) @(posedge clk); #1;
    rd(12'h400, v); chk("R4 start ignored", v, 32'h0C);
    rd(12'h410, v); chk("R4 no data", v, 0);

    wr(12'h404, 32'd5);
    rd(12'h404, v); chk("R5 period rw", v, 5);
    wr(12'h410, 32'hFFFF_FFFF);
    rd(12'h410, v); chk("R9 data write ignored", v, 0);
    rd(12'h408, v); chk("R9 unmapped 408", v, 0);
    rd(12'h7FC, v); chk("R9 unmapped 7FC", v, 0);
    rd(12'h430, v); chk("R9 unmapped 430", v, 0);
    rd(12'h412, v); chk("R9 unaligned", v, 0);

    for (int p = 0; p < 4; p++) begin
      for (int l = 3; l >= 0; l--) begin
        int pe, nb;
        pe = (p == 0) ? 1 : p;
        nb = 64 * (l + 1);
        wr(12'h404, 32'(p));
        wr(12'h400, 32'h003F_0000 | 32'(l << 4) | 32'h6);
        wr(12'h400, 32'h0001_0001);
        for (int k = 0; k < nb; k++) begin
          repeat (pe - 1) @(posedge clk);
          if (k == nb - 1) begin
            #1 rd(12'h400, v); chk("R2 busy before last", v, 32'(l << 4) | 32'h7);
          end
          @(posedge clk);
          exp_bits[k] = entropy_in;
        end
        #1 rd(12'h400, v); chk("R2 start self-clears", v, 32'(l << 4) | 32'h6);
        for (int w = 0; w < 8; w++) begin
          e = 0;
          if (w < nb / 32)
            for (int b = 0; b < 32; b++) e[b] = exp_bits[w*32 + b];
          rd(12'h410 + 12'(4*w), v); chk("R5 R6 R7 data word", v, e);
        end
        rd(12'h410, v);
        repeat (20) @(posedge clk); #1;
        rd(12'h410, v2); chk("R7 data held", v2, v);
      end
    end

    wr(12'h404, 32'd2);
    wr(12'h400, 32'h003F_0036);
    wr(12'h400, 32'h0001_0001);
    repeat (40) @(posedge clk); #1;
    wr(12'h400, 32'hFFFF_0000);
    rd(12'h400, v); chk("R8 disable", v, 0);
    rd(12'h410, v);
    repeat (30) @(posedge clk); #1;
    rd(12'h410, v2); chk("R8 bits kept", v2, v);
    rd(12'h42C, v); chk("R8 unreached word", v, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule